// File: doc/BRIEF.md
# Mailbox Doorbell and Interrupt Register Block

This block is the register face of a shared-memory mailbox endpoint. Software reaches it through a 256-byte window of 32-bit words. The window holds an interrupt mask, a status word that clears when read, a read-only word with the node's own position, and a write-only doorbell. A doorbell write packs a destination peer and a vector number into one word. The block checks that pair against a small per-peer vector-count table and then either issues a one-cycle notify strobe to the fabric or flags the write as rejected.

Events arriving on the node's own vectors are delivered in one of two ways, chosen by `msg_mode_i`. In level mode any event loads the value 1 into the status word, and a single interrupt line reflects status AND mask. In message mode each vector produces its own message pulse when messages are globally enabled. An event on a vector that is individually masked is parked in a pending bit and delivered once the vector is unmasked.

Top module: `mbox_doorbell_regs`

## Requirements
- R1: After reset the mask and status words read 0, `irq_o`, `msg_o` and `pend_o` are 0, and every peer's vector count is 0, so any doorbell is rejected.
- R2: A read returns its data on `rsp_rdata_o` with `rsp_valid_o` one cycle after the request. The read uses the exact byte address: 0x00 gives the mask, 0x04 the status, 0x08 `own_id_i` zero-extended, and 0x0C or any other address (including unaligned ones) gives 0.
- R3: A read of address 0x04 returns the current status and clears it to 0 in the same cycle, so `irq_o` drops after the read.
- R4: `irq_o` is high exactly when `irq_pin_en_i` is 1, `msg_mode_i` is 0 and (status AND mask) is nonzero.
- R5: A write decodes its address after clearing bits 1:0 (word index = address bits 7:2). Word 0 writes the mask, word 1 the status, and word 3 is the doorbell. Writes to word 2 or to any word from 4 up change nothing.
- R6: A doorbell write takes the destination from bits 31:16 and the vector from bits 7:0, ignoring bits 15:8. If the destination is below NUM_PEERS and the vector is below that peer's count, `ring_o` pulses for one cycle after the write, carrying the destination on `ring_dest_o` and the vector on `ring_vec_o`.
- R7: A doorbell whose destination is NUM_PEERS or above, or whose vector is not below the peer's count, gives a one-cycle `ring_err_o` pulse and no `ring_o`.
- R8: In level mode an event on any bit of `evt_i` loads the status with the value 1, overwriting it. This takes priority over a status write or a status read-clear in the same cycle.
- R9: In message mode with `msg_en_i` high, an event on an unmasked vector pulses that bit of `msg_o` one cycle later. With `msg_en_i` low the event is dropped and sets no pending bit. Message-mode events leave the status untouched.
- R10: In message mode with `msg_en_i` high, an event on a vector whose `vec_mask_i` bit is set raises its `pend_o` bit and sends no message. When that vector is later unmasked, `msg_o` pulses one cycle after the unmask and the pending bit clears.
- R11: A table write sets a peer's vector count from `tbl_cnt_i`, saturating at NUM_VEC. The new count governs the doorbells that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte address in the window |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| own_id_i | input | 16 | This node's position |
| tbl_we_i | input | 1 | Peer table write enable |
| tbl_peer_i | input | PEER_W | Peer table write index |
| tbl_cnt_i | input | CNT_W | Vector count to store |
| ring_o | output | 1 | Accepted doorbell strobe |
| ring_dest_o | output | 16 | Doorbell destination |
| ring_vec_o | output | 8 | Doorbell vector |
| ring_err_o | output | 1 | Rejected doorbell strobe |
| msg_mode_i | input | 1 | 1 = per-vector message mode, 0 = level mode |
| irq_pin_en_i | input | 1 | Level interrupt pin configured |
| msg_en_i | input | 1 | Message interrupts globally enabled |
| vec_mask_i | input | NUM_VEC | Per-vector message mask |
| evt_i | input | NUM_VEC | Incoming event per own vector |
| irq_o | output | 1 | Level interrupt |
| msg_o | output | NUM_VEC | Per-vector message pulse |
| pend_o | output | NUM_VEC | Per-vector pending bits |

## Verification
Several properties are checked on every cycle. The level line stays low in message mode or when no pin is configured. A doorbell never raises both strobes at once. An out-of-range destination always ends in an error strobe. A status read with no competing event leaves the line low. A message never fires for a vector that was masked the cycle before, nor without message mode and global enable. Other behaviour can only be shown by the bench's scenarios: the exact read values and the read-then-clear order, event priority over a same-cycle status write or read, the per-peer count limits including saturation, and the pending-then-unmask delivery.

// File: rtl/mbox_db_pkg.sv
package mbox_db_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned DEST_W = 16;
  localparam int unsigned VSEL_W = 8;

  typedef enum logic [WIDX_W-1:0] {
    W_MASK = 6'd0,
    W_STAT = 6'd1,
    W_OWN  = 6'd2,
    W_RING = 6'd3
  } word_e;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic [VSEL_W-1:0] vec;
  } ring_t;
endpackage

// File: rtl/mbox_peer_tbl.sv
module mbox_peer_tbl #(
  parameter int unsigned NUM_PEERS = 16,
  parameter int unsigned NUM_VEC   = 8,
  localparam int unsigned PEER_W   = $clog2(NUM_PEERS),
  localparam int unsigned CNT_W    = $clog2(NUM_VEC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PEER_W-1:0] wpeer_i,
  input  logic [CNT_W-1:0]  wcnt_i,
  input  mbox_db_pkg::ring_t chk_i,
  output logic              ok_o
);
  logic [CNT_W-1:0] cnt_q [NUM_PEERS];
  logic [CNT_W-1:0] wcnt_sat;
  logic [CNT_W-1:0] cnt_sel;
  logic             dest_ok;

  assign wcnt_sat = (32'(wcnt_i) > NUM_VEC) ? CNT_W'(NUM_VEC) : wcnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PEERS; i++) cnt_q[i] <= '0;
    end else if (we_i && (32'(wpeer_i) < NUM_PEERS)) begin
      cnt_q[wpeer_i] <= wcnt_sat;
    end
  end

  assign dest_ok = 32'(chk_i.dest) < NUM_PEERS;
  assign cnt_sel = cnt_q[chk_i.dest[PEER_W-1:0]];
  assign ok_o    = dest_ok && (32'(chk_i.vec) < 32'(cnt_sel));
endmodule

// File: rtl/mbox_lvl_irq.sv
module mbox_lvl_irq (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mask_we_i,
  input  logic        stat_we_i,
  input  logic        stat_rd_i,
  input  logic [31:0] wdata_i,
  input  logic        evt_i,
  input  logic        pin_act_i,
  output logic [31:0] mask_o,
  output logic [31:0] stat_o,
  output logic        irq_o
);
  logic [31:0] mask_q, stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i;
      // event overwrites, and wins over bus write and read-clear
      if (evt_i)          stat_q <= 32'd1;
      else if (stat_we_i) stat_q <= wdata_i;
      else if (stat_rd_i) stat_q <= '0;
    end
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = pin_act_i && |(stat_q & mask_q);
endmodule

// File: rtl/mbox_msg_vec.sv
module mbox_msg_vec #(
  parameter int unsigned NUM_VEC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               act_i,
  input  logic [NUM_VEC-1:0] evt_i,
  input  logic [NUM_VEC-1:0] mask_i,
  output logic [NUM_VEC-1:0] fire_o,
  output logic [NUM_VEC-1:0] pend_o
);
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    logic go, pend_q, fire_q, pend_d;

    assign go = act_i && !mask_i[g] && (evt_i[g] || pend_q);

    always_comb begin
      pend_d = pend_q;
      if (go)                                pend_d = 1'b0;
      else if (act_i && mask_i[g] && evt_i[g]) pend_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= 1'b0;
        fire_q <= 1'b0;
      end else begin
        pend_q <= pend_d;
        fire_q <= go;
      end
    end

    assign fire_o[g] = fire_q;
    assign pend_o[g] = pend_q;
  end
endmodule

// File: rtl/mbox_doorbell_regs.sv
module mbox_doorbell_regs #(
  parameter int unsigned NUM_PEERS = 16,
  parameter int unsigned NUM_VEC   = 8,
  localparam int unsigned PEER_W   = $clog2(NUM_PEERS),
  localparam int unsigned CNT_W    = $clog2(NUM_VEC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               req_we_i,
  input  logic [7:0]         req_addr_i,
  input  logic [31:0]        req_wdata_i,
  output logic               rsp_valid_o,
  output logic [31:0]        rsp_rdata_o,
  input  logic [15:0]        own_id_i,
  input  logic               tbl_we_i,
  input  logic [PEER_W-1:0]  tbl_peer_i,
  input  logic [CNT_W-1:0]   tbl_cnt_i,
  output logic               ring_o,
  output logic [15:0]        ring_dest_o,
  output logic [7:0]         ring_vec_o,
  output logic               ring_err_o,
  input  logic               msg_mode_i,
  input  logic               irq_pin_en_i,
  input  logic               msg_en_i,
  input  logic [NUM_VEC-1:0] vec_mask_i,
  input  logic [NUM_VEC-1:0] evt_i,
  output logic               irq_o,
  output logic [NUM_VEC-1:0] msg_o,
  output logic [NUM_VEC-1:0] pend_o
);
  import mbox_db_pkg::*;

  logic                wr, rd;
  logic [WIDX_W-1:0]   widx;
  logic                mask_we, stat_we, ring_we, stat_rd;
  logic [31:0]         mask_w, stat_w, rdata_d;
  ring_t               ring_req, ring_q;
  logic                ring_ok, ring_hit_q, ring_err_q;
  logic                rvalid_q;
  logic [31:0]         rdata_q;
  logic                lvl_evt;

  assign wr      = req_i && req_we_i;
  assign rd      = req_i && !req_we_i;
  assign widx    = req_addr_i[7:2];
  assign mask_we = wr && (widx == W_MASK);
  assign stat_we = wr && (widx == W_STAT);
  assign ring_we = wr && (widx == W_RING);
  assign stat_rd = rd && (req_addr_i == 8'h04);
  assign lvl_evt = !msg_mode_i && |evt_i;

  assign ring_req.dest = req_wdata_i[31:16];
  assign ring_req.vec  = req_wdata_i[7:0];

  mbox_peer_tbl #(.NUM_PEERS(NUM_PEERS), .NUM_VEC(NUM_VEC)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .wpeer_i (tbl_peer_i),
    .wcnt_i  (tbl_cnt_i),
    .chk_i   (ring_req),
    .ok_o    (ring_ok)
  );

  mbox_lvl_irq u_lvl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_we_i (mask_we),
    .stat_we_i (stat_we),
    .stat_rd_i (stat_rd),
    .wdata_i   (req_wdata_i),
    .evt_i     (lvl_evt),
    .pin_act_i (irq_pin_en_i && !msg_mode_i),
    .mask_o    (mask_w),
    .stat_o    (stat_w),
    .irq_o     (irq_o)
  );

  mbox_msg_vec #(.NUM_VEC(NUM_VEC)) u_msg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (msg_mode_i && msg_en_i),
    .evt_i  (evt_i),
    .mask_i (vec_mask_i),
    .fire_o (msg_o),
    .pend_o (pend_o)
  );

  // reads decode the exact byte address
  always_comb begin
    unique case (req_addr_i)
      8'h00:   rdata_d = mask_w;
      8'h04:   rdata_d = stat_w;
      8'h08:   rdata_d = {16'h0, own_id_i};
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q   <= 1'b0;
      rdata_q    <= '0;
      ring_hit_q <= 1'b0;
      ring_err_q <= 1'b0;
      ring_q     <= '0;
    end else begin
      rvalid_q   <= rd;
      if (rd) rdata_q <= rdata_d;
      ring_hit_q <= ring_we && ring_ok;
      ring_err_q <= ring_we && !ring_ok;
      if (ring_we) ring_q <= ring_req;
    end
  end

  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;
  assign ring_o      = ring_hit_q;
  assign ring_err_o  = ring_err_q;
  assign ring_dest_o = ring_q.dest;
  assign ring_vec_o  = ring_q.vec;
endmodule

// File: rtl/mbox_doorbell_regs_chk.sv
module mbox_doorbell_regs_chk #(
  parameter int unsigned NUM_PEERS = 16,
  parameter int unsigned NUM_VEC   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               req_we_i,
  input logic [7:0]         req_addr_i,
  input logic [31:0]        req_wdata_i,
  input logic               ring_o,
  input logic [15:0]        ring_dest_o,
  input logic               ring_err_o,
  input logic               msg_mode_i,
  input logic               irq_pin_en_i,
  input logic               msg_en_i,
  input logic [NUM_VEC-1:0] vec_mask_i,
  input logic [NUM_VEC-1:0] evt_i,
  input logic               irq_o,
  input logic [NUM_VEC-1:0] msg_o
);
  p_irq_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_mode_i || !irq_pin_en_i) |-> !irq_o);

  p_rd_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !req_we_i && req_addr_i == 8'h04 && !(!msg_mode_i && |evt_i)) |=> !irq_o);

  p_ring_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ring_o && ring_err_o));

  p_bad_dest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_we_i && req_addr_i[7:2] == 6'd3 && 32'(req_wdata_i[31:16]) >= NUM_PEERS)
    |=> (ring_err_o && !ring_o));

  p_ring_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_o |-> (32'(ring_dest_o) < NUM_PEERS));

  p_msg_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|msg_o) |-> $past(msg_mode_i && msg_en_i));

  p_msg_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|msg_o) |-> ((msg_o & $past(vec_mask_i)) == '0));
endmodule

bind mbox_doorbell_regs mbox_doorbell_regs_chk #(.NUM_PEERS(NUM_PEERS), .NUM_VEC(NUM_VEC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .req_we_i     (req_we_i),
  .req_addr_i   (req_addr_i),
  .req_wdata_i  (req_wdata_i),
  .ring_o       (ring_o),
  .ring_dest_o  (ring_dest_o),
  .ring_err_o   (ring_err_o),
  .msg_mode_i   (msg_mode_i),
  .irq_pin_en_i (irq_pin_en_i),
  .msg_en_i     (msg_en_i),
  .vec_mask_i   (vec_mask_i),
  .evt_i        (evt_i),
  .irq_o        (irq_o),
  .msg_o        (msg_o)
);

// File: tb/mbox_doorbell_regs_test.sv
module mbox_doorbell_regs_test;
  localparam int unsigned NP = 16;
  localparam int unsigned NV = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, req_we_i = 1'b0;
  logic [7:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic [15:0] own_id_i = 16'h00A5;
  logic        tbl_we_i = 1'b0;
  logic [3:0]  tbl_peer_i = '0;
  logic [3:0]  tbl_cnt_i = '0;
  logic        ring_o, ring_err_o;
  logic [15:0] ring_dest_o;
  logic [7:0]  ring_vec_o;
  logic        msg_mode_i = 1'b0, irq_pin_en_i = 1'b1, msg_en_i = 1'b0;
  logic [NV-1:0] vec_mask_i = '0, evt_i = '0;
  logic        irq_o;
  logic [NV-1:0] msg_o, pend_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] rv;

  always #2 clk_i = ~clk_i;

  mbox_doorbell_regs #(.NUM_PEERS(NP), .NUM_VEC(NV)) uut (.*);

  // doorbell vectors: {write data, expect accept}
  localparam logic [32:0] DB_VEC [11] = '{
    {32'h0000_0000, 1'b1},
    {32'h0000_0007, 1'b1},
    {32'h0000_0008, 1'b0},
    {32'h0001_0001, 1'b1},
    {32'h0001_0002, 1'b0},
    {32'h0003_0000, 1'b0},
    {32'h000F_0000, 1'b0},
    {32'h0010_0000, 1'b0},
    {32'hFFFF_0000, 1'b0},
    {32'h0001_AB01, 1'b1},
    {32'h0002_0007, 1'b1}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_i = 1'b1; req_we_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    tick();
    req_i = 1'b0; req_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req_i = 1'b1; req_we_i = 1'b0; req_addr_i = a;
    tick();
    req_i = 1'b0;
    d = rsp_rdata_o;
    chk("R2 rvalid", 32'(rsp_valid_o), 32'd1);
  endtask

  task automatic tbl(input logic [3:0] p, input logic [3:0] c);
    tbl_we_i = 1'b1; tbl_peer_i = p; tbl_cnt_i = c;
    tick();
    tbl_we_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 pend", 32'(pend_o), 0);
    chk("R1 msg", 32'(msg_o), 0);
    rd(8'h00, rv); chk("R1 mask", rv, 0);
    rd(8'h04, rv); chk("R1 status", rv, 0);
    wr(8'h0C, 32'h0000_0000);
    chk("R1 empty table err", 32'(ring_err_o), 1);
    chk("R1 empty table ring", 32'(ring_o), 0);

    // R11 table load, peer 2 saturates to NV
    tbl(4'd0, 4'd8); tbl(4'd1, 4'd2); tbl(4'd2, 4'd15);

    // R6 R7 vector walk
    foreach (DB_VEC[i]) begin
      wr(8'h0C, DB_VEC[i][32:1]);
      chk("R6 ring", 32'(ring_o), 32'(DB_VEC[i][0]));
      chk("R7 err", 32'(ring_err_o), 32'(!DB_VEC[i][0]));
      if (DB_VEC[i][0]) begin
        chk("R6 dest", 32'(ring_dest_o), 32'(DB_VEC[i][32:17]));
        chk("R6 vec", 32'(ring_vec_o), 32'(DB_VEC[i][8:1]));
      end
      tick();
      chk("R6 one cycle", 32'({ring_o, ring_err_o}), 0);
    end
    chk("R11 saturated count admits vec 7", 32'(ring_vec_o), 7);

    // R5 address masking and ignored writes
    wr(8'h0D, 32'h0000_0003);
    chk("R5 masked doorbell", 32'(ring_o), 1);
    chk("R5 masked doorbell vec", 32'(ring_vec_o), 3);
    wr(8'h02, 32'h0000_00C3);
    rd(8'h00, rv); chk("R5 masked mask write", rv, 32'h0000_00C3);
    wr(8'h10, 32'hFFFF_FFFF);
    chk("R5 undefined write no ring", 32'({ring_o, ring_err_o}), 0);
    wr(8'h08, 32'h1234_5678);
    rd(8'h00, rv); chk("R5 mask untouched", rv, 32'h0000_00C3);
    rd(8'h04, rv); chk("R5 status untouched", rv, 0);

    // R2 read map
    rd(8'h08, rv); chk("R2 own id", rv, 32'h0000_00A5);
    rd(8'h0C, rv); chk("R2 doorbell reads zero", rv, 0);
    rd(8'h20, rv); chk("R2 undefined reads zero", rv, 0);
    wr(8'h04, 32'h0000_0009);
    rd(8'h05, rv); chk("R2 unaligned reads zero", rv, 0);

    // R3 read clears
    rd(8'h04, rv); chk("R3 first read", rv, 32'h0000_0009);
    rd(8'h04, rv); chk("R3 cleared", rv, 0);

    // R4 level line
    wr(8'h00, 32'h0000_0004);
    wr(8'h04, 32'h0000_0005);
    chk("R4 irq set", 32'(irq_o), 1);
    irq_pin_en_i = 1'b0; #1;
    chk("R4 no pin", 32'(irq_o), 0);
    irq_pin_en_i = 1'b1; msg_mode_i = 1'b1; #1;
    chk("R4 message mode", 32'(irq_o), 0);
    msg_mode_i = 1'b0; #1;
    wr(8'h00, 32'h0000_0002);
    chk("R4 masked off", 32'(irq_o), 0);
    wr(8'h00, 32'h0000_0004);
    chk("R4 unmasked", 32'(irq_o), 1);
    rd(8'h04, rv);
    chk("R3 irq drops after read", 32'(irq_o), 0);

    // R8 level events
    wr(8'h00, 32'h0000_0001);
    wr(8'h04, 32'h0000_00F0);
    chk("R8 irq before event", 32'(irq_o), 0);
    evt_i = 8'h40; tick(); evt_i = '0;
    chk("R8 irq after event", 32'(irq_o), 1);
    rd(8'h04, rv); chk("R8 overwrite to 1", rv, 1);
    evt_i = 8'h01; wr(8'h04, 32'h0000_0030); evt_i = '0;
    rd(8'h04, rv); chk("R8 event beats write", rv, 1);
    evt_i = 8'h02; rd(8'h04, rv); evt_i = '0;
    chk("R8 read returns old", rv, 0);
    rd(8'h04, rv); chk("R8 event beats clear", rv, 1);

    // R9 message mode
    msg_mode_i = 1'b1; msg_en_i = 1'b1; vec_mask_i = '0;
    evt_i = 8'h04; tick(); evt_i = '0;
    chk("R9 msg pulse", 32'(msg_o), 32'h04);
    tick();
    chk("R9 pulse ends", 32'(msg_o), 0);
    rd(8'h04, rv); chk("R9 status untouched", rv, 0);
    msg_en_i = 1'b0;
    evt_i = 8'h08; tick(); evt_i = '0;
    chk("R9 disabled no msg", 32'(msg_o), 0);
    chk("R9 disabled no pend", 32'(pend_o), 0);

    // R10 pending and unmask
    msg_en_i = 1'b1; vec_mask_i = 8'h10;
    evt_i = 8'h10; tick(); evt_i = '0;
    chk("R10 masked no msg", 32'(msg_o), 0);
    chk("R10 pend set", 32'(pend_o), 32'h10);
    tick();
    chk("R10 pend held", 32'(pend_o), 32'h10);
    vec_mask_i = '0; tick();
    chk("R10 unmask sends", 32'(msg_o), 32'h10);
    chk("R10 pend cleared", 32'(pend_o), 0);
    tick();
    chk("R10 single pulse", 32'(msg_o), 0);

    // R1 reset again clears state
    wr(8'h00, 32'hFFFF_FFFF);
    rst_ni = 1'b0; tick(); rst_ni = 1'b1; tick();
    msg_mode_i = 1'b0;
    rd(8'h00, rv); chk("R1 mask after reset", rv, 0);
    wr(8'h0C, 32'h0000_0000);
    chk("R1 table cleared", 32'(ring_err_o), 1);

    finish_run();
  end
endmodule